// File: doc/BRIEF.md
# Fast-Path Frame Classifier

This block watches a stream of received Ethernet frames, one 32-bit word per beat, and sorts each frame into one of three classes as it ends. The frame is stored with two bytes of padding ahead of the Ethernet header, so every header field falls at a fixed word position. The classifier does not parse or validate headers in full. It samples a few fixed words as they pass, so a decision is ready one cycle after the last word of the frame, with no buffering of the frame itself.

Frames that carry streaming sample data to the configured UDP port go to the fast path. Frames with the private address-recovery ethertype and tag go to the recovery handler, which receives the IPv4 address found in the frame. Every other frame goes to the slow path. Each frame also gets a length, counted in words. The result stays on the outputs until the consumer acknowledges it.

Top module: `fpc_classifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `res_valid` is 0.
- R2: The beat with `in_valid` and `in_sof` both high is word 0 of a new frame, even when it arrives before the previous frame's end. Each later beat with `in_valid` high is the next word. Cycles with `in_valid` low are not counted and change nothing.
- R3: A frame is fast-path (class 1) when bits 15:0 of word 9 equal `cfg_data_port` and word 11 differs from `cfg_bad_hdr`.
- R4: A frame whose word 11 equals `cfg_bad_hdr` is never fast-path, even when the port in word 9 matches.
- R5: A frame is recovery (class 2) when bits 15:0 of word 3 (the ethertype) equal 0xBEEE, word 4 equals 0x61646472 ("addr", first character in bits 31:24), and the frame reaches word 5. In that case `res_addr` carries word 5. For any other class, `res_addr` is 0.
- R6: When a frame meets the conditions of both R3 and R5, it is reported as fast-path.
- R7: Every other frame is slow-path (class 0). For every class, `res_len` is the index of the frame's last word minus 3, with a floor of 0.
- R8: A result is loaded in the cycle after the beat that carries `in_eof`. From then on, `res_valid` stays high and class, length and address hold until a cycle with `res_ack` high. `res_valid` is low in the cycle after that, unless another frame ended in the same cycle as the acknowledge, in which case its result is loaded instead.
- R9: A frame whose last word is before word 11 is never fast-path. A frame whose last word is before word 5 is never recovery.
- R10: The class code takes only the values 0 (slow), 1 (fast) and 2 (recovery) while `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is present this cycle |
| in_sof | input | 1 | This word is word 0 of a frame |
| in_eof | input | 1 | This word is the last of the frame |
| in_data | input | 32 | Frame word, earliest byte in bits 31:24 |
| cfg_data_port | input | 16 | UDP destination port of fast-path data |
| cfg_bad_hdr | input | 32 | Stream-header value that marks a frame as not fast-path |
| res_ack | input | 1 | Consumer accepts the current result |
| res_valid | output | 1 | A classification result is present |
| res_class | output | 2 | 0 slow, 1 fast, 2 recovery |
| res_len | output | IDX_W (11) | Last word index minus 3, with a floor of 0 |
| res_addr | output | 32 | Recovered IPv4 address, 0 unless the class is recovery |

## Verification
The assertions assume that every frame opens with a start beat, that no words arrive between one frame's end and the next frame's start, and that the configuration inputs stay constant while a frame is in flight. The stimulus only builds frames with an explicit start word, changes no configuration during a run, and places idle cycles only inside frames or between a frame's end and the next start. Within those limits it covers frames that end at the boundary words, frames that restart partway through, results left unacknowledged across idle cycles, and an acknowledge that falls in the same cycle as a frame end.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   typedef enum logic [1:0] {
      CLS_SLOW  = 2'd0,
      CLS_FAST  = 2'd1,
      CLS_RECOV = 2'd2
   } fpc_class_e;

   // word positions fixed by the two-byte pad ahead of the Ethernet header
   localparam int unsigned W_ETYPE = 3;
   localparam int unsigned W_TAG   = 4;
   localparam int unsigned W_ADDR  = 5;
   localparam int unsigned W_PORT  = 9;
   localparam int unsigned W_HDR   = 11;

   // header words ahead of the payload length count
   localparam int unsigned LEN_BIAS = 3;

   localparam logic [15:0] RECOV_ETYPE = 16'hBEEE;
   localparam logic [31:0] RECOV_TAG   = 32'h61646472;

   // match flag positions
   localparam int unsigned F_PORT  = 0;
   localparam int unsigned F_HDR   = 1;
   localparam int unsigned F_ETYPE = 2;
   localparam int unsigned F_TAG   = 3;
   localparam int unsigned F_ADDR  = 4;
   localparam int unsigned F_NUM   = 5;

endpackage

// File: rtl/fpc_beat_index.sv
module fpc_beat_index #(
   parameter int unsigned IDX_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_vld,
   input  logic             beat_first,
   output logic [IDX_W-1:0] cur_idx
);
   localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

   logic [IDX_W-1:0] idx_q;

   assign cur_idx = beat_first ? '0 : idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (beat_vld) begin
         if (cur_idx != IDX_MAX)
            idx_q <= cur_idx + 1'b1;
         else
            idx_q <= IDX_MAX;
      end
   end
endmodule

// File: rtl/fpc_field_scan.sv
module fpc_field_scan
   import fpc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 11,
   parameter int unsigned PORT_W   = 16,
   parameter bit          RECOV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_vld,
   input  logic              beat_first,
   input  logic [DATA_W-1:0] beat_data,
   input  logic [IDX_W-1:0]  cur_idx,
   input  logic [PORT_W-1:0] cfg_port,
   input  logic [DATA_W-1:0] cfg_bad,
   output logic              now_fast,
   output logic              now_recov,
   output logic [DATA_W-1:0] now_addr
);
   logic [F_NUM-1:0]  flag_q;
   logic [F_NUM-1:0]  flag_base;
   logic [F_NUM-1:0]  flag_hit;
   logic [F_NUM-1:0]  flag_nxt;
   logic [DATA_W-1:0] addr_q;
   logic              at_port;
   logic              at_hdr;

   assign at_port = beat_vld && (cur_idx == IDX_W'(W_PORT));
   assign at_hdr  = beat_vld && (cur_idx == IDX_W'(W_HDR));

   assign flag_hit[F_PORT] = at_port && (beat_data[PORT_W-1:0] == cfg_port);
   assign flag_hit[F_HDR]  = at_hdr && (beat_data != cfg_bad);

   generate
      if (RECOV_EN) begin : g_recov
         logic at_etype;
         logic at_tag;
         logic at_addr;
         assign at_etype = beat_vld && (cur_idx == IDX_W'(W_ETYPE));
         assign at_tag   = beat_vld && (cur_idx == IDX_W'(W_TAG));
         assign at_addr  = beat_vld && (cur_idx == IDX_W'(W_ADDR));
         assign flag_hit[F_ETYPE] = at_etype && (beat_data[15:0] == RECOV_ETYPE);
         assign flag_hit[F_TAG]   = at_tag && (beat_data == DATA_W'(RECOV_TAG));
         assign flag_hit[F_ADDR]  = at_addr;
         assign now_addr  = at_addr ? beat_data : addr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               addr_q <= '0;
            else if (at_addr)
               addr_q <= beat_data;
         end
      end else begin : g_norecov
         assign flag_hit[F_ETYPE] = 1'b0;
         assign flag_hit[F_TAG]   = 1'b0;
         assign flag_hit[F_ADDR]  = 1'b0;
         assign now_addr = '0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               addr_q <= '0;
            else
               addr_q <= '0;
         end
      end
   endgenerate

   assign flag_base = beat_first ? '0 : flag_q;
   assign flag_nxt  = flag_base | flag_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= '0;
      else if (beat_vld)
         flag_q <= flag_nxt;
   end

   assign now_fast  = flag_nxt[F_PORT] && flag_nxt[F_HDR];
   assign now_recov = flag_nxt[F_ETYPE] && flag_nxt[F_TAG] && flag_nxt[F_ADDR];
endmodule

// File: rtl/fpc_result_hold.sv
module fpc_result_hold #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ack,
   input  logic [1:0]        cls_in,
   input  logic [IDX_W-1:0]  len_in,
   input  logic [DATA_W-1:0] addr_in,
   output logic              valid,
   output logic [1:0]        cls,
   output logic [IDX_W-1:0]  len,
   output logic [DATA_W-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         cls   <= '0;
         len   <= '0;
         addr  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         cls   <= cls_in;
         len   <= len_in;
         addr  <= addr_in;
      end else if (ack) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/fpc_classifier.sv
module fpc_classifier
   import fpc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 11,
   parameter int unsigned PORT_W   = 16,
   parameter bit          RECOV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [DATA_W-1:0] in_data,
   input  logic [PORT_W-1:0] cfg_data_port,
   input  logic [DATA_W-1:0] cfg_bad_hdr,
   input  logic              res_ack,
   output logic              res_valid,
   output logic [1:0]        res_class,
   output logic [IDX_W-1:0]  res_len,
   output logic [DATA_W-1:0] res_addr
);
   localparam logic [IDX_W-1:0] BIAS = IDX_W'(LEN_BIAS);

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("fpc_classifier: DATA_W must be 32");
      end
      if (IDX_W < 4) begin : g_bad_idx_w
         $error("fpc_classifier: IDX_W too small to reach word 11");
      end
      if (PORT_W > DATA_W) begin : g_bad_port_w
         $error("fpc_classifier: PORT_W wider than a word");
      end
   endgenerate

   logic              beat_vld;
   logic              beat_first;
   logic              frame_end;
   logic [IDX_W-1:0]  cur_idx;
   logic              now_fast;
   logic              now_recov;
   logic [DATA_W-1:0] now_addr;
   fpc_class_e        cls_sel;
   logic [IDX_W-1:0]  len_sel;
   logic [DATA_W-1:0] addr_sel;

   assign beat_vld   = in_valid;
   assign beat_first = in_valid && in_sof;
   assign frame_end  = in_valid && in_eof;

   fpc_beat_index #(.IDX_W(IDX_W)) u_index (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_vld   (beat_vld),
      .beat_first (beat_first),
      .cur_idx    (cur_idx)
   );

   fpc_field_scan #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .PORT_W   (PORT_W),
      .RECOV_EN (RECOV_EN)
   ) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_vld   (beat_vld),
      .beat_first (beat_first),
      .beat_data  (in_data),
      .cur_idx    (cur_idx),
      .cfg_port   (cfg_data_port),
      .cfg_bad    (cfg_bad_hdr),
      .now_fast   (now_fast),
      .now_recov  (now_recov),
      .now_addr   (now_addr)
   );

   // fast path wins over recovery
   always_comb begin
      if (now_fast)
         cls_sel = CLS_FAST;
      else if (now_recov)
         cls_sel = CLS_RECOV;
      else
         cls_sel = CLS_SLOW;
   end

   assign len_sel  = (cur_idx >= BIAS) ? (cur_idx - BIAS) : '0;
   assign addr_sel = (cls_sel == CLS_RECOV) ? now_addr : '0;

   fpc_result_hold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (frame_end),
      .ack     (res_ack),
      .cls_in  (cls_sel),
      .len_in  (len_sel),
      .addr_in (addr_sel),
      .valid   (res_valid),
      .cls     (res_class),
      .len     (res_len),
      .addr    (res_addr)
   );
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 11,
   parameter bit          RECOV_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_eof,
   input logic              res_ack,
   input logic              res_valid,
   input logic [1:0]        res_class,
   input logic [IDX_W-1:0]  res_len,
   input logic [DATA_W-1:0] res_addr
);
   logic frame_end;
   assign frame_end = in_valid && in_eof;

   assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> res_valid);

   assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid) |-> $past(frame_end));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ack && !frame_end) |=>
         (res_valid && $stable(res_class) && $stable(res_len) && $stable(res_addr)));

   assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_ack && !frame_end) |=> !res_valid);

   assert_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_class != 2'd3));

   assert_fast_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_class == 2'd1) |-> (res_len >= IDX_W'(8)));

   assert_recov_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_class == 2'd2) |-> (res_len >= IDX_W'(2)));

   assert_addr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_class != 2'd2) |-> (res_addr == '0));

   assert_recov_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !RECOV_EN) |-> (res_class != 2'd2));
endmodule

bind fpc_classifier fpc_checker #(
   .DATA_W   (DATA_W),
   .IDX_W    (IDX_W),
   .RECOV_EN (RECOV_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_eof    (in_eof),
   .res_ack   (res_ack),
   .res_valid (res_valid),
   .res_class (res_class),
   .res_len   (res_len),
   .res_addr  (res_addr)
);

// File: tb/fpc_classifier_tb.sv
`timescale 1ns/1ps
module fpc_classifier_tb;
   localparam int IDX_W = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_sof = 1'b0;
   logic             in_eof = 1'b0;
   logic [31:0]      in_data = '0;
   logic [15:0]      cfg_data_port = 16'hC001;
   logic [31:0]      cfg_bad_hdr = 32'hDEAD0000;
   logic             res_ack = 1'b0;
   logic             res_valid;
   logic [1:0]       res_class;
   logic [IDX_W-1:0] res_len;
   logic [31:0]      res_addr;

   always #5 clk = ~clk;

   fpc_classifier u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_sof        (in_sof),
      .in_eof        (in_eof),
      .in_data       (in_data),
      .cfg_data_port (cfg_data_port),
      .cfg_bad_hdr   (cfg_bad_hdr),
      .res_ack       (res_ack),
      .res_valid     (res_valid),
      .res_class     (res_class),
      .res_len       (res_len),
      .res_addr      (res_addr)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string cur_req = "R1";

   // ---------------- behavioural reference model ----------------
   logic [31:0]      mq[$];
   logic             e_valid = 1'b0;
   logic [1:0]       e_class = '0;
   logic [IDX_W-1:0] e_len = '0;
   logic [31:0]      e_addr = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         e_valid = 1'b0;
         e_class = '0;
         e_len   = '0;
         e_addr  = '0;
      end else if (in_valid) begin
         if (in_sof) mq.delete();
         mq.push_back(in_data);
         if (in_eof) begin
            int  n;
            bit  fast;
            bit  rec;
            n    = mq.size();
            fast = (n > 11) && (mq[9][15:0] == cfg_data_port) && (mq[11] != cfg_bad_hdr);
            rec  = (n > 5) && (mq[3][15:0] == 16'hBEEE) && (mq[4] == 32'h61646472);
            e_valid = 1'b1;
            e_class = fast ? 2'd1 : (rec ? 2'd2 : 2'd0);
            e_len   = (n - 1 >= 3) ? IDX_W'(n - 4) : '0;
            e_addr  = (!fast && rec) ? mq[5] : 32'h0;
         end else if (res_ack) begin
            e_valid = 1'b0;
         end
      end else if (res_ack) begin
         e_valid = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_vec++;
         if (res_valid !== e_valid) begin
            n_bad++;
            $display("FAIL %s valid actual=%0b expected=%0b t=%0t", cur_req, res_valid, e_valid, $time);
         end else if (e_valid && (res_class !== e_class || res_len !== e_len || res_addr !== e_addr)) begin
            n_bad++;
            $display("FAIL %s result actual=%0d/%0d/%h expected=%0d/%0d/%h t=%0t",
                     cur_req, res_class, res_len, res_addr, e_class, e_len, e_addr, $time);
         end
      end
   end

   // ---------------- stimulus ----------------
   logic [31:0] sf[$];

   task automatic build(input int n, input logic [15:0] port, input logic [31:0] hdr,
                        input logic [15:0] et, input logic [31:0] tag, input logic [31:0] ip);
      sf.delete();
      for (int i = 0; i < n; i++) begin
         logic [31:0] w;
         w = $urandom;
         if (i == 3)  w = {16'h1234, et};
         if (i == 4)  w = tag;
         if (i == 5)  w = ip;
         if (i == 9)  w = {16'h0A0B, port};
         if (i == 11) w = hdr;
         sf.push_back(w);
      end
   endtask

   task automatic send(input bit gaps);
      for (int i = 0; i < sf.size(); i++) begin
         if (gaps && (i % 3 == 1)) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
            in_eof   = 1'b0;
            in_data  = $urandom;
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_eof   = (i == sf.size() - 1);
         in_data  = sf[i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
   endtask

   task automatic ack_now();
      @(negedge clk);
      res_ack = 1'b1;
      @(negedge clk);
      res_ack = 1'b0;
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   localparam logic [31:0] TAG = 32'h61646472;

   initial begin : main
      idle(3);
      // R1: reset state
      n_vec++;
      if (res_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 valid in reset actual=%0b expected=0", res_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if (res_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 valid after reset actual=%0b expected=0", res_valid);
      end

      cur_req = "R3";  // fast path
      build(16, 16'hC001, 32'h10000001, 16'h0800, 32'h0, 32'h0); send(0); ack_now();
      build(12, 16'hC001, 32'h0, 16'h0800, 32'h0, 32'h0); send(1); ack_now();

      cur_req = "R4";  // invalid stream header
      build(16, 16'hC001, 32'hDEAD0000, 16'h0800, 32'h0, 32'h0); send(0); ack_now();

      cur_req = "R5";  // recovery
      build(8, 16'h0001, 32'h0, 16'hBEEE, TAG, 32'hC0A80A02); send(0); ack_now();
      build(6, 16'h0001, 32'h0, 16'hBEEE, TAG, 32'h0A000001); send(1); ack_now();
      build(8, 16'h0001, 32'h0, 16'hBEEE, 32'h61646473, 32'h01020304); send(0); ack_now();
      build(8, 16'h0001, 32'h0, 16'hBEEF, TAG, 32'h01020304); send(0); ack_now();

      cur_req = "R6";  // both match: fast wins
      build(14, 16'hC001, 32'h5, 16'hBEEE, TAG, 32'hAABBCCDD); send(0); ack_now();

      cur_req = "R7";  // slow path and length floor
      build(20, 16'h1234, 32'h5, 16'h0800, 32'h0, 32'h0); send(1); ack_now();
      build(2, 16'h0, 32'h0, 16'h0, 32'h0, 32'h0); send(0); ack_now();
      build(1, 16'h0, 32'h0, 16'h0, 32'h0, 32'h0); send(0); ack_now();
      build(4, 16'h0, 32'h0, 16'h0, 32'h0, 32'h0); send(0); ack_now();

      cur_req = "R9";  // too short for the class
      build(11, 16'hC001, 32'h5, 16'h0800, 32'h0, 32'h0); send(0); ack_now();
      build(5, 16'h0, 32'h0, 16'hBEEE, TAG, 32'h0); send(0); ack_now();

      cur_req = "R8";  // hold without ack, ack coincident with frame end
      build(16, 16'hC001, 32'h7, 16'h0800, 32'h0, 32'h0); send(0);
      idle(6);
      build(9, 16'h0, 32'h0, 16'hBEEE, TAG, 32'h11223344);
      for (int i = 0; i < sf.size(); i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_eof   = (i == sf.size() - 1);
         in_data  = sf[i];
         res_ack  = (i == sf.size() - 1);
      end
      @(negedge clk);
      in_valid = 1'b0; in_eof = 1'b0; res_ack = 1'b0;
      idle(3);
      ack_now();
      idle(2);

      cur_req = "R2";  // restart mid-frame, idle beats inside frame
      build(7, 16'hC001, 32'h0, 16'h0800, 32'h0, 32'h0);
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sof = (i == 0); in_eof = 1'b0; in_data = sf[i];
      end
      build(13, 16'hC001, 32'h3, 16'h0800, 32'h0, 32'h0); send(1); ack_now();

      cur_req = "R10"; // code range over a mix of frames
      for (int k = 0; k < 12; k++) begin
         build(6 + (k % 10), (k % 2) ? 16'hC001 : 16'h0002, (k % 3) ? 32'h9 : 32'hDEAD0000,
               (k % 4 < 2) ? 16'hBEEE : 16'h86DD, TAG, 32'h0 + k);
         send(k % 2);
         if (k % 3 != 0) ack_now();
      end
      ack_now();
      idle(4);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule